// File: doc/BRIEF.md
# Life-cycle state transition controller

This block holds a device's life-cycle state and the number of transitions made so far, and carries out one requested move to a later state per reset. A power-manager init request makes it load the encoded state words and the encoded count from a nonvolatile-memory input. It validates both, exposes them on status outputs, and drives broadcast enables that depend on the state. A malformed encoding sends it to a permanent escalation state and raises a state-failure alert.

Software first writes a target state index, then a multi-word token, then a command word. The controller then does the following in order. It refuses the request if the count is exhausted. It programs an incremented count into memory. It checks that the move is legal and that the token matches. It completes a clock-bypass handshake, and for the final state a flash-erase handshake as well. Last, it programs the new state. Every attempt ends in a terminal state that only reset leaves. A program error, or an escalation input, drives the controller to the escalation state. The escalation input also sets an escalate-enable output that stays high until reset.

Top module: `lcs_transition_ctrl`

## Requirements
- R1: State word i (NW=4 words of 16 bits, word i at bits 16i+15:16i) has a clear code {8'hA5^i, 8'h3C+i} and a set code that is its bitwise inverse. State s (0..NW) has words 0..s-1 set and the rest clear. The count word is {~c, c} in bytes and is legal for c<=16. After reset, status_o and en_o are 0. One cycle after init_req_i samples legal inputs, status_o is 1 (ready), state_o=s, cnt_o=c, and en_o[i]=1 exactly for i<=s.
- R2: A state pattern other than those of R1 (a word in the wrong position, a set word after a clear word, random data) or a bad count word (halves not inverse, or c>16) sets status bit 8 and pulses alert_state_o for one cycle. The controller then enters escalation, with ready 0 and en_o 0.
- R3: Register writes go to address 0 (target index, bits IW-1:0), addresses 1..2 (token words, low word first) and address 3 (command, bit 0 starts the request). They take effect only while ready. The target register resets to 0.
- R4: A target that is not greater than the current state, or that is greater than NW, sets status bit 3 (illegal move).
- R5: A move to current+1 expects the fixed token UNCOND_TOKEN. Any other move expects cond_token_i. A mismatch sets status bit 4.
- R6: A command first programs the current state words with count c+1. cnt_o shows c+1 even if a later step fails.
- R7: If cnt_o is 16 when the command arrives, status bit 2 is set and no program request is made.
- R8: A legal, matching move raises byp_req_o. An error reply sets bit 6. A move to state NW then raises erase_req_o, and an error reply sets bit 5.
- R9: A successful move programs the target words. It sets state_o to the target and status bit 1, and en_o stays 0 from then on.
- R10: A program acknowledge with error sets status bit 7, pulses alert_prog_o and enters escalation. A count-phase error leaves cnt_o unchanged.
- R11: After any attempt, further commands are ignored until reset: no requests are made and status does not change.
- R12: esc_i sets esc_en_o, which stays set until reset. The controller enters escalation and drops ready and en_o.
- R13: status bit 9 follows mem_data_err_i one cycle later and clears when the input clears, without reset.
- R14: Error status bits 2..8 never clear except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| init_req_i | input | 1 | Power-manager init request |
| mem_state_i | input | 16*NW | Encoded state words from memory |
| mem_cnt_i | input | 16 | Encoded transition count from memory |
| mem_data_err_i | input | 1 | Memory data error flag |
| cond_token_i | input | TOKW | Expected token for conditional moves |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | 32 | Register write data |
| prog_req_o | output | 1 | Memory program request |
| prog_ack_i | input | 1 | Program acknowledge |
| prog_err_i | input | 1 | Program error, valid with acknowledge |
| prog_state_o | output | 16*NW | State words to program |
| prog_cnt_o | output | 16 | Count word to program |
| byp_req_o | output | 1 | Clock-bypass request |
| byp_ack_i | input | 1 | Clock-bypass acknowledge |
| byp_err_i | input | 1 | Clock-bypass error |
| erase_req_o | output | 1 | Flash-erase request |
| erase_ack_i | input | 1 | Flash-erase acknowledge |
| erase_err_i | input | 1 | Flash-erase error |
| esc_i | input | 1 | Escalation input |
| esc_en_o | output | 1 | Latched escalate enable |
| en_o | output | NW+1 | Broadcast enables |
| state_o | output | IW | Current state index |
| cnt_o | output | 8 | Current transition count |
| status_o | output | 10 | Ready, success and error bits |
| alert_prog_o | output | 1 | Program-failure alert pulse |
| alert_state_o | output | 1 | State-failure alert pulse |

## Verification
Ready, state_o, cnt_o, en_o and the state-failure alert are due in the cycle after the edge that samples init_req_i. The bench samples them at the next falling edge. Status bit 9 follows its input with the same one-cycle delay. Each handshake step takes one cycle for the request and one for the acknowledge, so a full attempt ends within about eight cycles. The bench waits twenty cycles before comparing the final status, state and count, and it counts every handshake and alert pulse as it happens. The bench checks that a repeated command is ignored by watching these counters and the status for ten more cycles.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  localparam int unsigned CNT_W = 8;

  typedef enum logic [7:0] {
    ST_RESET  = 8'h3A,
    ST_IDLE   = 8'hC5,
    ST_CNTPRG = 8'h96,
    ST_CHECK  = 8'h6C,
    ST_BYP    = 8'hE1,
    ST_ERASE  = 8'h1E,
    ST_STPRG  = 8'hB4,
    ST_DONE   = 8'h4B,
    ST_POST   = 8'hD2,
    ST_ESC    = 8'h27
  } fsm_e;

  function automatic logic [15:0] clr_code(input int unsigned pos);
    logic [7:0] b;
    b = 8'(pos);
    return {8'hA5 ^ b, 8'h3C + b};
  endfunction

  function automatic logic [15:0] set_code(input int unsigned pos);
    return ~clr_code(pos);
  endfunction

  function automatic logic [2*CNT_W-1:0] cnt_enc(input logic [CNT_W-1:0] c);
    return {~c, c};
  endfunction

  function automatic logic cnt_word_ok(input logic [2*CNT_W-1:0] w,
                                       input int unsigned cmax);
    return (w[2*CNT_W-1:CNT_W] == ~w[CNT_W-1:0]) &&
           (w[CNT_W-1:0] <= CNT_W'(cmax));
  endfunction

endpackage

// File: rtl/lcs_state_codec.sv
module lcs_state_codec #(
  parameter int unsigned NW = 4,
  parameter int unsigned IW = 3
) (
  input  logic [16*NW-1:0] words_i,
  output logic [IW-1:0]    idx_o,
  output logic             valid_o,
  input  logic [IW-1:0]    enc_idx_i,
  output logic [16*NW-1:0] words_o
);
  logic [NW-1:0] is_set, is_clr;

  for (genvar g = 0; g < NW; g++) begin : g_word
    assign is_set[g] = words_i[g*16 +: 16] == lcs_pkg::set_code(g);
    assign is_clr[g] = words_i[g*16 +: 16] == lcs_pkg::clr_code(g);
    assign words_o[g*16 +: 16] = (enc_idx_i > IW'(g)) ? lcs_pkg::set_code(g)
                                                       : lcs_pkg::clr_code(g);
  end

  always_comb begin
    valid_o = is_set[0] | is_clr[0];
    idx_o   = is_set[0] ? IW'(1) : '0;
    for (int i = 1; i < NW; i++) begin
      if (!(is_set[i] | is_clr[i])) valid_o = 1'b0;
      if (is_set[i] && !is_set[i-1]) valid_o = 1'b0;
      if (is_set[i]) idx_o = idx_o + IW'(1);
    end
  end
endmodule

// File: rtl/lcs_rule.sv
module lcs_rule #(
  parameter int unsigned NW   = 4,
  parameter int unsigned IW   = 3,
  parameter int unsigned TOKW = 64,
  parameter logic [TOKW-1:0] UNCOND_TOKEN = '0
) (
  input  logic [IW-1:0]   cur_i,
  input  logic [IW-1:0]   tgt_i,
  input  logic [TOKW-1:0] tok_i,
  input  logic [TOKW-1:0] cond_tok_i,
  output logic            legal_o,
  output logic            match_o
);
  logic uncond;
  assign uncond  = {1'b0, tgt_i} == ({1'b0, cur_i} + 1'b1);
  assign legal_o = (tgt_i > cur_i) && (tgt_i <= IW'(NW));
  assign match_o = tok_i == (uncond ? UNCOND_TOKEN : cond_tok_i);
endmodule

// File: rtl/lcs_esc_latch.sv
module lcs_esc_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic esc_i,
  output logic esc_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    esc_en_o <= 1'b0;
    else if (esc_i) esc_en_o <= 1'b1;
  end
endmodule

// File: rtl/lcs_transition_ctrl.sv
module lcs_transition_ctrl #(
  parameter int unsigned NW      = 4,
  parameter int unsigned TOKW    = 64,
  parameter int unsigned CNT_MAX = 16,
  parameter logic [TOKW-1:0] UNCOND_TOKEN = 64'h0123_4567_89AB_CDEF,
  localparam int unsigned SW   = 16 * NW,
  localparam int unsigned IW   = $clog2(NW + 1),
  localparam int unsigned CW   = lcs_pkg::CNT_W,
  localparam int unsigned TOKN = TOKW / 32,
  localparam int unsigned AW   = $clog2(TOKN + 2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_req_i,
  input  logic [SW-1:0]   mem_state_i,
  input  logic [2*CW-1:0] mem_cnt_i,
  input  logic            mem_data_err_i,
  input  logic [TOKW-1:0] cond_token_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [31:0]     wr_data_i,
  output logic            prog_req_o,
  input  logic            prog_ack_i,
  input  logic            prog_err_i,
  output logic [SW-1:0]   prog_state_o,
  output logic [2*CW-1:0] prog_cnt_o,
  output logic            byp_req_o,
  input  logic            byp_ack_i,
  input  logic            byp_err_i,
  output logic            erase_req_o,
  input  logic            erase_ack_i,
  input  logic            erase_err_i,
  input  logic            esc_i,
  output logic            esc_en_o,
  output logic [NW:0]     en_o,
  output logic [IW-1:0]   state_o,
  output logic [CW-1:0]   cnt_o,
  output logic [9:0]      status_o,
  output logic            alert_prog_o,
  output logic            alert_state_o
);
  import lcs_pkg::*;

  localparam logic [AW-1:0] CMD_ADDR = AW'(TOKN + 1);

  fsm_e            st_q, st_d;
  logic [IW-1:0]   cur_q, tgt_q, dec_idx, enc_idx;
  logic [CW-1:0]   cnt_q;
  logic [TOKW-1:0] tok_q;
  logic [6:0]      errs_q, errs_set;
  logic            data_err_q;

  // named internal events
  logic dec_valid, load_ok, load_fail, cmd_fire, cnt_exhausted;
  logic move_legal, tok_match, ready, terminal;

  lcs_state_codec #(.NW(NW), .IW(IW)) u_codec (
    .words_i   (mem_state_i),
    .idx_o     (dec_idx),
    .valid_o   (dec_valid),
    .enc_idx_i (enc_idx),
    .words_o   (prog_state_o)
  );

  lcs_rule #(.NW(NW), .IW(IW), .TOKW(TOKW), .UNCOND_TOKEN(UNCOND_TOKEN)) u_rule (
    .cur_i      (cur_q),
    .tgt_i      (tgt_q),
    .tok_i      (tok_q),
    .cond_tok_i (cond_token_i),
    .legal_o    (move_legal),
    .match_o    (tok_match)
  );

  lcs_esc_latch u_esc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .esc_i    (esc_i),
    .esc_en_o (esc_en_o)
  );

  assign load_ok       = dec_valid && cnt_word_ok(mem_cnt_i, CNT_MAX);
  assign load_fail     = (st_q == ST_RESET) && init_req_i && !load_ok;
  assign ready         = st_q == ST_IDLE;
  assign terminal      = (st_q == ST_DONE) || (st_q == ST_POST) || (st_q == ST_ESC);
  assign cmd_fire      = ready && wr_en_i && (wr_addr_i == CMD_ADDR) && wr_data_i[0];
  assign cnt_exhausted = cnt_q >= CW'(CNT_MAX);
  assign enc_idx       = (st_q == ST_STPRG) ? tgt_q : cur_q;

  // errs_set bit order: 0 count, 1 illegal, 2 token, 3 erase, 4 bypass, 5 program, 6 state
  always_comb begin
    st_d     = st_q;
    errs_set = '0;
    unique case (st_q)
      ST_RESET: if (init_req_i) begin
        st_d        = load_ok ? ST_IDLE : ST_ESC;
        errs_set[6] = !load_ok;
      end
      ST_IDLE: if (cmd_fire) begin
        st_d        = cnt_exhausted ? ST_POST : ST_CNTPRG;
        errs_set[0] = cnt_exhausted;
      end
      ST_CNTPRG: if (prog_ack_i) begin
        st_d        = prog_err_i ? ST_ESC : ST_CHECK;
        errs_set[5] = prog_err_i;
      end
      ST_CHECK: begin
        st_d        = (move_legal && tok_match) ? ST_BYP : ST_POST;
        errs_set[1] = !move_legal;
        errs_set[2] = move_legal && !tok_match;
      end
      ST_BYP: if (byp_ack_i) begin
        st_d        = byp_err_i ? ST_POST : ((tgt_q == IW'(NW)) ? ST_ERASE : ST_STPRG);
        errs_set[4] = byp_err_i;
      end
      ST_ERASE: if (erase_ack_i) begin
        st_d        = erase_err_i ? ST_POST : ST_STPRG;
        errs_set[3] = erase_err_i;
      end
      ST_STPRG: if (prog_ack_i) begin
        st_d        = prog_err_i ? ST_ESC : ST_DONE;
        errs_set[5] = prog_err_i;
      end
      ST_DONE, ST_POST, ST_ESC: st_d = st_q;
      default: st_d = ST_ESC;
    endcase
    if (esc_i || esc_en_o) st_d = ST_ESC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_RESET;
      cur_q         <= '0;
      tgt_q         <= '0;
      cnt_q         <= '0;
      tok_q         <= '0;
      errs_q        <= '0;
      data_err_q    <= 1'b0;
      alert_prog_o  <= 1'b0;
      alert_state_o <= 1'b0;
    end else begin
      st_q          <= st_d;
      errs_q        <= errs_q | errs_set;
      data_err_q    <= mem_data_err_i;
      alert_prog_o  <= errs_set[5];
      alert_state_o <= errs_set[6];
      if ((st_q == ST_RESET) && init_req_i && load_ok) begin
        cur_q <= dec_idx;
        cnt_q <= mem_cnt_i[CW-1:0];
      end
      if ((st_q == ST_CNTPRG) && prog_ack_i && !prog_err_i) cnt_q <= cnt_q + CW'(1);
      if ((st_q == ST_STPRG) && prog_ack_i && !prog_err_i) cur_q <= tgt_q;
      if (ready && wr_en_i) begin
        if (wr_addr_i == '0) tgt_q <= wr_data_i[IW-1:0];
        for (int w = 0; w < TOKN; w++)
          if (wr_addr_i == AW'(w + 1)) tok_q[w*32 +: 32] <= wr_data_i;
      end
    end
  end

  for (genvar i = 0; i <= NW; i++) begin : g_en
    assign en_o[i] = ready && (cur_q >= IW'(i));
  end

  assign prog_req_o  = (st_q == ST_CNTPRG) || (st_q == ST_STPRG);
  assign prog_cnt_o  = cnt_enc((st_q == ST_CNTPRG) ? cnt_q + CW'(1) : cnt_q);
  assign byp_req_o   = st_q == ST_BYP;
  assign erase_req_o = st_q == ST_ERASE;
  assign state_o     = cur_q;
  assign cnt_o       = cnt_q;
  assign status_o    = {data_err_q, errs_q, st_q == ST_DONE, ready};
endmodule

// File: rtl/lcs_transition_ctrl_chk.sv
module lcs_transition_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [9:0] status_o,
  input logic       en_any,
  input logic       prog_req_o,
  input logic       prog_ack_i,
  input logic       prog_err_i,
  input logic       byp_req_o,
  input logic       erase_req_o,
  input logic       esc_i,
  input logic       esc_en_o,
  input logic       alert_prog_o,
  input logic       alert_state_o,
  input logic       load_fail,
  input logic       cmd_fire,
  input logic       cnt_exhausted,
  input logic       terminal
);
  assert_state_fail_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fail |=> (alert_state_o && status_o[8] && !status_o[0]));

  assert_cnt_exhaust_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_fire && cnt_exhausted) |=> (status_o[2] && !prog_req_o));

  assert_bcast_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[0] |-> !en_any);

  assert_prog_fail_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && prog_ack_i && prog_err_i) |=> (alert_prog_o && status_o[7]));

  assert_terminal_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    terminal |=> (terminal && !prog_req_o && !byp_req_o && !erase_req_o));

  assert_esc_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc_i || esc_en_o) |=> (esc_en_o && !status_o[0]));

  assert_err_sticky_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o[8:2] & $past(status_o[8:2])) == $past(status_o[8:2])));
endmodule

bind lcs_transition_ctrl lcs_transition_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .status_o      (status_o),
  .en_any        (|en_o),
  .prog_req_o    (prog_req_o),
  .prog_ack_i    (prog_ack_i),
  .prog_err_i    (prog_err_i),
  .byp_req_o     (byp_req_o),
  .erase_req_o   (erase_req_o),
  .esc_i         (esc_i),
  .esc_en_o      (esc_en_o),
  .alert_prog_o  (alert_prog_o),
  .alert_state_o (alert_state_o),
  .load_fail     (load_fail),
  .cmd_fire      (cmd_fire),
  .cnt_exhausted (cnt_exhausted),
  .terminal      (terminal)
);

// File: tb/lcs_transition_ctrl_tb.sv
module lcs_transition_ctrl_tb;
  localparam logic [63:0] UT = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] CT = 64'hFACE_0FF1_CE00_BEEF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        init_req = 0, data_err = 0, wr_en = 0, esc = 0;
  logic [63:0] mstate = '0;
  logic [15:0] mcnt = '0;
  logic [1:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic prog_req, prog_ack = 0, prog_err = 0;
  logic byp_req, byp_ack = 0, byp_err = 0;
  logic era_req, era_ack = 0, era_err = 0;
  logic esc_en, al_prog, al_state;
  logic [63:0] pstate;
  logic [15:0] pcnt;
  logic [4:0]  en;
  logic [2:0]  st;
  logic [7:0]  cnt;
  logic [9:0]  status;

  lcs_transition_ctrl #(.UNCOND_TOKEN(UT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .init_req_i(init_req), .mem_state_i(mstate),
    .mem_cnt_i(mcnt), .mem_data_err_i(data_err), .cond_token_i(CT),
    .wr_en_i(wr_en), .wr_addr_i(waddr), .wr_data_i(wdata),
    .prog_req_o(prog_req), .prog_ack_i(prog_ack), .prog_err_i(prog_err),
    .prog_state_o(pstate), .prog_cnt_o(pcnt),
    .byp_req_o(byp_req), .byp_ack_i(byp_ack), .byp_err_i(byp_err),
    .erase_req_o(era_req), .erase_ack_i(era_ack), .erase_err_i(era_err),
    .esc_i(esc), .esc_en_o(esc_en), .en_o(en), .state_o(st), .cnt_o(cnt),
    .status_o(status), .alert_prog_o(al_prog), .alert_state_o(al_state));

  int total = 0, fails = 0;
  int prog_n = 0, byp_n = 0, era_n = 0, alp_n = 0;
  int pe_at = -1;
  bit be = 0, ee = 0, done = 0;
  logic [63:0] last_pstate;
  logic [15:0] last_pcnt;

  // handshake responder: one-cycle acknowledge per request
  always @(negedge clk) begin
    if (prog_req && !prog_ack) begin
      last_pstate = pstate; last_pcnt = pcnt;
      prog_ack = 1; prog_err = (prog_n == pe_at); prog_n++;
    end else begin prog_ack = 0; prog_err = 0; end
    if (byp_req && !byp_ack) begin byp_ack = 1; byp_err = be; byp_n++; end
    else begin byp_ack = 0; byp_err = 0; end
    if (era_req && !era_ack) begin era_ack = 1; era_err = ee; era_n++; end
    else begin era_ack = 0; era_err = 0; end
    if (al_prog) alp_n++;
  end

  function automatic logic [15:0] wclr(int i);
    return {8'hA5 ^ 8'(i), 8'h3C + 8'(i)};
  endfunction
  function automatic logic [63:0] senc(int s);
    logic [63:0] r;
    for (int i = 0; i < 4; i++) r[i*16 +: 16] = (i < s) ? ~wclr(i) : wclr(i);
    return r;
  endfunction
  function automatic logic [15:0] cenc(int c);
    return {~8'(c), 8'(c)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; init_req = 0; wr_en = 0; esc = 0; data_err = 0;
    repeat (3) @(negedge clk);
    prog_n = 0; byp_n = 0; era_n = 0; alp_n = 0;
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic init(input logic [63:0] w, input logic [15:0] c);
    @(negedge clk); mstate = w; mcnt = c; init_req = 1;
    @(negedge clk); init_req = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; waddr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic run(input int s, input int c, input int tgt, input bit good,
                     input int pe, input bit b_e, input bit e_e, input string tag);
    logic [63:0] tok;
    logic [9:0]  es;
    int est, ecnt, eprog, eera;
    do_reset();
    pe_at = pe; be = b_e; ee = e_e;
    init(senc(s), cenc(c));
    chk(status == 10'h001 && st == 3'(s), {tag, " R1 ready"}, status, 1);
    tok = (tgt == s + 1) ? UT : CT;
    if (!good) tok = tok ^ 64'h1;
    wr(2'd0, 32'(tgt)); wr(2'd1, tok[31:0]); wr(2'd2, tok[63:32]); wr(2'd3, 32'h1);
    repeat (20) @(negedge clk);
    es = '0; est = s; ecnt = c; eprog = 0; eera = 0;
    if (c >= 16) es[2] = 1;
    else if (pe == 0) begin es[7] = 1; eprog = 1; end
    else begin
      ecnt = c + 1; eprog = 1;
      if (!(tgt > s && tgt <= 4)) es[3] = 1;
      else if (!good) es[4] = 1;
      else if (b_e) es[6] = 1;
      else if (tgt == 4 && e_e) begin es[5] = 1; eera = 1; end
      else begin
        eera = (tgt == 4); eprog = 2;
        if (pe == 1) es[7] = 1; else begin es[1] = 1; est = tgt; end
      end
    end
    chk(status == es, {tag, " R4 R5 R7 R8 R9 R10 status"}, status, es);
    chk(st == 3'(est), {tag, " R9 state"}, st, est);
    chk(cnt == 8'(ecnt), {tag, " R6 count"}, cnt, ecnt);
    chk(en == 5'd0, {tag, " R9 enables off"}, en, 0);
    chk(prog_n == eprog, {tag, " R6 R7 program handshakes"}, prog_n, eprog);
    chk(era_n == eera, {tag, " R8 erase handshakes"}, era_n, eera);
    if (es[7]) chk(alp_n == 1 && esc_en == 0, {tag, " R10 alert"}, alp_n, 1);
    if (eprog == 2 && pe != 1)
      chk(last_pstate == senc(tgt) && last_pcnt == cenc(c + 1), {tag, " R9 programmed words"},
          last_pstate, senc(tgt));
    // R11: a second command after the attempt is ignored
    wr(2'd3, 32'h1);
    repeat (10) @(negedge clk);
    chk(prog_n == eprog && status == es, {tag, " R11 R14 ignored"}, status, es);
  endtask

  task automatic bad_load(input logic [63:0] w, input logic [15:0] c, input string tag);
    do_reset();
    init(w, c);
    chk(al_state == 1 && status == 10'h100 && en == 0, {tag, " R2 state failure"},
        {al_state, status}, 10'h100);
    @(negedge clk);
    chk(al_state == 0 && status == 10'h100, {tag, " R2 alert single pulse"}, al_state, 0);
  endtask

  task automatic finish_up();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
    end
  end

  initial begin
    // R1: reset state and init for every legal state
    for (int s = 0; s <= 4; s++) begin
      do_reset();
      chk(status == 0 && en == 0, "R1 reset state", status, 0);
      init(senc(s), cenc(s + 5));
      chk(status == 10'h001, "R1 ready", status, 1);
      chk(st == 3'(s) && cnt == 8'(s + 5), "R1 state/count", {st, cnt}, {3'(s), 8'(s + 5)});
      chk(en == 5'((1 << (s + 1)) - 1), "R1 enables", en, (1 << (s + 1)) - 1);
    end
    // R4 R5 R9: sweep every state/target pair with correct token
    for (int s = 0; s <= 4; s++)
      for (int t = 0; t < 8; t++) run(s, 3, t, 1, -1, 0, 0, $sformatf("sweep s%0d t%0d", s, t));
    run(1, 2, 2, 0, -1, 0, 0, "R5 uncond mismatch");
    run(0, 2, 3, 0, -1, 0, 0, "R5 cond mismatch");
    run(0, 15, 2, 1, -1, 0, 0, "R7 count 15");
    run(0, 16, 2, 1, -1, 0, 0, "R7 count 16");
    run(1, 4, 3, 1, -1, 1, 0, "R8 bypass error");
    run(2, 4, 4, 1, -1, 0, 1, "R8 erase error");
    run(2, 4, 4, 1, -1, 1, 0, "R8 bypass error before erase");
    run(0, 1, 1, 1, 0, 0, 0, "R10 count program error");
    run(0, 1, 1, 1, 1, 0, 0, "R10 state program error");
    // R2: malformed encodings
    begin
      logic [63:0] w;
      w = senc(2); w[15:0] = senc(2)[31:16]; w[31:16] = senc(2)[15:0];
      bad_load(w, cenc(1), "swapped words");
      w = senc(0); w[31:16] = ~wclr(1);
      bad_load(w, cenc(1), "set after clear");
    end
    bad_load(64'h1234_5678_9ABC_DEF0, cenc(1), "random words");
    bad_load(senc(1), cenc(17), "count above 16");
    bad_load(senc(1), 16'h0101, "count halves");
    // R3: writes before ready are ignored; target stays 0
    do_reset();
    wr(2'd0, 32'd3); wr(2'd1, CT[31:0]); wr(2'd2, CT[63:32]); wr(2'd3, 32'h1);
    chk(prog_n == 0 && status == 0, "R3 write before init", prog_n, 0);
    init(senc(1), cenc(2));
    wr(2'd3, 32'h1);
    repeat (20) @(negedge clk);
    chk(status == 10'h008 && prog_n == 1, "R3 target kept at reset value", status, 10'h008);
    // R3: command with bit 0 clear does nothing
    do_reset();
    init(senc(1), cenc(2));
    wr(2'd3, 32'h2);
    repeat (5) @(negedge clk);
    chk(status == 10'h001 && prog_n == 0, "R3 command bit 0 clear", status, 1);
    // R13: data error follows input
    @(negedge clk); data_err = 1;
    @(negedge clk);
    chk(status == 10'h201, "R13 data error set", status, 10'h201);
    data_err = 0;
    @(negedge clk);
    chk(status == 10'h001, "R13 data error cleared", status, 1);
    // R12: escalation latch
    @(negedge clk); esc = 1;
    @(negedge clk); esc = 0;
    chk(esc_en == 1 && status[0] == 0 && en == 0, "R12 escalate", {esc_en, status}, 11'h400);
    wr(2'd3, 32'h1);
    repeat (10) @(negedge clk);
    chk(esc_en == 1 && prog_n == 0 && status == 0, "R12 stays set", {esc_en, status}, 11'h400);
    do_reset();
    chk(esc_en == 0, "R12 reset clears", esc_en, 0);
    done = 1;
    finish_up();
  end
endmodule